// File: doc/BRIEF.md
# Bridge PWM Generator with Fault Shutdown

This block produces a pulse-width modulated drive for up to four power-stage pins. A prescaled time base counts in quarter steps against an 8-bit period register, and a 10-bit duty value, loaded only at the start of each period, sets how long the main PWM signal stays high. The signal is steered to one pin, to a complementary half-bridge pair with programmable dead time, or to a full bridge turning in either direction. The pins form two pairs, A/C and B/D, and the polarity of each pair can be inverted.

A shutdown unit watches three digital fault lines through a two-flop synchroniser. When a selected line is active, the pins are forced to a safe level programmed for each pair: low, high or released. A shutdown flag records the event. Software clears the flag in manual mode. In automatic mode the flag clears by itself once the fault is gone. In either mode the pins resume only at the next period boundary. Configuration goes through a simple write-only register port.

Top module: `epwm_bridge`

## Requirements
- R1: After reset all pins drive 0 and the shutdown flag is 0. From the first clock edge after reset, only pin A (index 0) is enabled (pwm_oe = 4'b0001), and it stays low because the duty is 0.
- R2: While RUN[0] is 1, the time base advances one quarter step every 1, 4 or 16 clocks. The rate is set by CFG[7:6]: 00 gives 1, 01 gives 4, 1x gives 16. A period lasts 4*(PER+1) quarter steps. While RUN[0] is 0, the count holds.
- R3: The duty value is {DUTY_HI, CFG[5:4]}. The main PWM signal is high while the quarter-step count within the period is below the active duty. A newly written duty becomes active only at the next period start.
- R4: An active duty of 4*(PER+1) or more keeps the main PWM signal high for the whole period.
- R5: CFG[1:0] selects the steering. Pins are indexed A=0, B=1, C=2, D=3.
  - 00 (single): only A is enabled and it carries the PWM.
  - 01 (half-bridge): A carries the PWM and B its complement; C and D are released.
  - 10 (full bridge, forward): A is held active and D carries the PWM.
  - 11 (full bridge, reverse): C is held active and B carries the PWM.
  - In both full-bridge modes the two remaining pins are inactive and all four pins are enabled.
- R6: CFG[2] inverts the level of pins A and C, and CFG[3] inverts pins B and D. A released pin drives 0.
- R7: In half-bridge mode, each rising edge of A and of B is delayed by DEAD[6:0] clocks. Falling edges are not delayed, so A and B are never active together.
- R8: FAULT[2:0] enables the fault_in lines bit by bit. A selected line that is high for two clocks forces the pins at the next edge to safe levels: FAULT[4:3] sets pins A/C and FAULT[6:5] sets pins B/D. The codes are 00 for drive low, 01 for drive high, and 1x for released (oe 0). An unselected line has no effect.
- R9: shut_flag is set at the same edge at which the pins are forced. A fault wins over a simultaneous write to the flag.
- R10: With DEAD[7]=0 (manual), the flag stays set after the fault goes away. It clears only when FAULT is written with bit 7 = 0; writing bit 7 = 1 sets it.
- R11: With DEAD[7]=1 (automatic), a set flag clears at the first edge at which no selected synchronised fault is present.
- R12: Once the flag and the fault are both clear, the pins stay at their safe levels until a period boundary. They then resume from the start of the new period.
- R13: The register addresses are PER=0, DUTY_HI=1, CFG=2, DEAD=3, FAULT=4 and RUN=5. A write takes effect from the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| fault_in | input | 3 | Asynchronous fault lines |
| pwm_out | output | 4 | Pin levels A,B,C,D (bit 0 = A) |
| pwm_oe | output | 4 | Pin drive enables |
| shut_flag | output | 1 | Shutdown status |

## Verification
The bench changes the duty in the middle of a period. A design without the shadow load would show a shortened or stretched pulse in that period. It sets the duty above the period, where an off-by-one compare would leave a one-step gap. It runs half-bridge mode with a dead time, where a design that also delayed falling edges, or that did not restart its delay count, would produce overlapping or missing pulses. It pulses a fault in manual and in automatic recovery and raises an unselected line. A design that resumed before the period boundary would release the pins mid-period. Mishandled synchroniser timing would shift the forced edge by a cycle, and a missing source mask would force the pins on the unselected line.

// File: rtl/epwm_pkg.sv
package epwm_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE   = 2'b00,
    MODE_HALF     = 2'b01,
    MODE_FULL_FWD = 2'b10,
    MODE_FULL_REV = 2'b11
  } bridge_mode_e;

  typedef struct packed {
    logic [3:0] oe;
    logic [3:0] lvl;
  } pin_set_t;

  // clocks per quarter step, minus one
  function automatic logic [3:0] presc_limit(input logic [1:0] sel);
    case (sel)
      2'b00:   return 4'd0;
      2'b01:   return 4'd3;
      default: return 4'd15;
    endcase
  endfunction

  // logical lane levels per steering mode, pin index A=0 .. D=3
  function automatic pin_set_t steer_lanes(input bridge_mode_e m, input logic pwm,
                                           input logic lane_a, input logic lane_b);
    pin_set_t p;
    case (m)
      MODE_SINGLE:   begin p.oe = 4'b0001; p.lvl = {3'b000, pwm}; end
      MODE_HALF:     begin p.oe = 4'b0011; p.lvl = {2'b00, lane_b, lane_a}; end
      MODE_FULL_FWD: begin p.oe = 4'b1111; p.lvl = {pwm, 2'b00, 1'b1}; end
      default:       begin p.oe = 4'b1111; p.lvl = {1'b0, 1'b1, pwm, 1'b0}; end
    endcase
    return p;
  endfunction

  // safe-state code: 00 low, 01 high, 1x released
  function automatic pin_set_t safe_pins(input logic [1:0] ac, input logic [1:0] bd);
    pin_set_t p;
    p.oe  = {~bd[1], ~ac[1], ~bd[1], ~ac[1]};
    p.lvl = {~bd[1] & bd[0], ~ac[1] & ac[0], ~bd[1] & bd[0], ~ac[1] & ac[0]};
    return p;
  endfunction

endpackage

// File: rtl/epwm_timebase.sv
module epwm_timebase #(
  parameter int PER_W  = 8,
  parameter int FINE_W = 2,
  localparam int CNT_W = PER_W + FINE_W,
  localparam int PS_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [1:0]       presc_sel,
  input  logic [PER_W-1:0] period,
  input  logic [CNT_W-1:0] duty_next,
  output logic             raw_pwm,
  output logic             period_start,
  output logic [CNT_W-1:0] duty_live
);
  import epwm_pkg::*;

  logic [PS_W-1:0]   ps_q;
  logic [PER_W-1:0]  coarse_q;
  logic [FINE_W-1:0] fine_q;
  logic [CNT_W-1:0]  duty_q;
  logic              tick;
  logic              wrap;

  assign tick         = run && (ps_q >= presc_limit(presc_sel));
  assign wrap         = (coarse_q >= period) && (&fine_q);
  assign period_start = tick && wrap;
  assign raw_pwm      = {coarse_q, fine_q} < duty_q;
  assign duty_live    = duty_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q     <= '0;
      coarse_q <= '0;
      fine_q   <= '0;
      duty_q   <= '0;
    end else begin
      if (run) ps_q <= tick ? '0 : ps_q + 1'b1;
      if (tick) begin
        if (wrap) begin
          coarse_q <= '0;
          fine_q   <= '0;
        end else begin
          fine_q <= fine_q + 1'b1;
          if (&fine_q) coarse_q <= coarse_q + 1'b1;
        end
      end
      if (period_start) duty_q <= duty_next;
    end
  end
endmodule

// File: rtl/epwm_deadband.sv
module epwm_deadband #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_sig,
  input  logic [CW-1:0] dead,
  output logic          out_sig
);
  logic [CW-1:0] cnt_q;

  assign out_sig = in_sig && (cnt_q >= dead);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!in_sig)      cnt_q <= '0;
    else if (cnt_q < dead) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/epwm_fault.sv
module epwm_fault #(
  parameter int N_FLT = 3,
  parameter int SYNC  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_FLT-1:0] fault_raw,
  input  logic [N_FLT-1:0] src_en,
  input  logic             auto_rs,
  input  logic             sw_wr,
  input  logic             sw_val,
  input  logic             period_start,
  output logic             fault_hit,
  output logic             status,
  output logic             force_safe
);
  logic [SYNC-1:0][N_FLT-1:0] sq;
  logic status_q;
  logic hold_q;

  assign fault_hit  = |(sq[SYNC-1] & src_en);
  assign status     = status_q;
  assign force_safe = status_q || fault_hit || hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq       <= '0;
      status_q <= 1'b0;
      hold_q   <= 1'b0;
    end else begin
      sq <= {sq[SYNC-2:0], fault_raw};
      if (fault_hit)               status_q <= 1'b1;
      else if (sw_wr)              status_q <= sw_val;
      else if (auto_rs && status_q) status_q <= 1'b0;
      if (status_q || fault_hit)   hold_q <= 1'b1;
      else if (period_start)       hold_q <= 1'b0;
    end
  end
endmodule

// File: rtl/epwm_bridge.sv
module epwm_bridge #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  parameter int N_FLT  = 3,
  parameter int DB_W   = 7,
  localparam int PER_W  = DATA_W,
  localparam int DUTY_W = PER_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [N_FLT-1:0]  fault_in,
  output logic [3:0]        pwm_out,
  output logic [3:0]        pwm_oe,
  output logic              shut_flag
);
  import epwm_pkg::*;

  localparam logic [ADDR_W-1:0] A_PER  = 0;
  localparam logic [ADDR_W-1:0] A_DUTY = 1;
  localparam logic [ADDR_W-1:0] A_CFG  = 2;
  localparam logic [ADDR_W-1:0] A_DEAD = 3;
  localparam logic [ADDR_W-1:0] A_FLT  = 4;
  localparam logic [ADDR_W-1:0] A_RUN  = 5;

  logic [PER_W-1:0] per_r;
  logic [PER_W-1:0] dhi_r;
  logic [7:0]       cfg_r;
  logic [DB_W:0]    dead_r;
  logic [6:0]       flt_r;
  logic             run_r;

  logic              raw_pwm, period_start;
  logic [DUTY_W-1:0] duty_live;
  logic [1:0]        lane;
  logic              lane_a, lane_b;
  logic              fault_hit, force_safe, fault_wr;
  logic              half_mode, auto_rs;
  pin_set_t          norm_set, safe_set, next_set;
  logic [3:0]        inv_mask;
  logic [3:0]        safe_oe, safe_out;

  // register write port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_r  <= '1;
      dhi_r  <= '0;
      cfg_r  <= '0;
      dead_r <= '0;
      flt_r  <= '0;
      run_r  <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        A_PER:  per_r  <= wr_data;
        A_DUTY: dhi_r  <= wr_data;
        A_CFG:  cfg_r  <= wr_data[7:0];
        A_DEAD: dead_r <= wr_data[DB_W:0];
        A_FLT:  flt_r  <= wr_data[6:0];
        A_RUN:  run_r  <= wr_data[0];
        default: ;
      endcase
    end
  end

  assign fault_wr  = wr_en && (wr_addr == A_FLT);
  assign auto_rs   = dead_r[DB_W];
  assign half_mode = bridge_mode_e'(cfg_r[1:0]) == MODE_HALF;

  epwm_timebase #(.PER_W(PER_W), .FINE_W(2)) u_tb (
    .clk, .rst_n,
    .run          (run_r),
    .presc_sel    (cfg_r[7:6]),
    .period       (per_r),
    .duty_next    ({dhi_r, cfg_r[5:4]}),
    .raw_pwm      (raw_pwm),
    .period_start (period_start),
    .duty_live    (duty_live)
  );

  // one dead-band lane for the signal, one for its complement
  for (genvar g = 0; g < 2; g++) begin : g_lane
    epwm_deadband #(.CW(DB_W)) u_db (
      .clk, .rst_n,
      .in_sig  ((g == 0) ? raw_pwm : ~raw_pwm),
      .dead    (dead_r[DB_W-1:0]),
      .out_sig (lane[g])
    );
  end
  assign lane_a = lane[0];
  assign lane_b = lane[1];

  epwm_fault #(.N_FLT(N_FLT), .SYNC(2)) u_flt (
    .clk, .rst_n,
    .fault_raw    (fault_in),
    .src_en       (flt_r[N_FLT-1:0]),
    .auto_rs      (auto_rs),
    .sw_wr        (fault_wr),
    .sw_val       (wr_data[DATA_W-1]),
    .period_start (period_start),
    .fault_hit    (fault_hit),
    .status       (shut_flag),
    .force_safe   (force_safe)
  );

  // steering, polarity and safe-state selection
  assign inv_mask = {cfg_r[3], cfg_r[2], cfg_r[3], cfg_r[2]};
  assign safe_set = safe_pins(flt_r[4:3], flt_r[6:5]);
  assign safe_oe  = safe_set.oe;
  assign safe_out = safe_set.lvl;

  always_comb begin
    norm_set     = steer_lanes(bridge_mode_e'(cfg_r[1:0]), raw_pwm, lane_a, lane_b);
    norm_set.lvl = norm_set.oe & (norm_set.lvl ^ inv_mask);
    next_set     = force_safe ? safe_set : norm_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_out <= '0;
      pwm_oe  <= '0;
    end else begin
      pwm_out <= next_set.lvl;
      pwm_oe  <= next_set.oe;
    end
  end
endmodule

// File: rtl/epwm_bridge_chk.sv
module epwm_bridge_chk #(
  parameter int DUTY_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lane_a,
  input logic              lane_b,
  input logic              fault_hit,
  input logic              force_safe,
  input logic              fault_wr,
  input logic              auto_rs,
  input logic              period_start,
  input logic [DUTY_W-1:0] duty_live,
  input logic              shut_flag,
  input logic [3:0]        pwm_out,
  input logic [3:0]        pwm_oe,
  input logic [3:0]        safe_out,
  input logic [3:0]        safe_oe
);
  AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !period_start |=> $stable(duty_live)); // R3

  AST_DEAD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(lane_a && lane_b)); // R7

  AST_SAFE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    force_safe |=> (pwm_oe == $past(safe_oe)) && (pwm_out == $past(safe_out))); // R8

  AST_FLAG_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    fault_hit |=> shut_flag); // R9

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (shut_flag && !auto_rs && !fault_hit && !fault_wr) |=> shut_flag); // R10

  AST_AUTO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (shut_flag && auto_rs && !fault_hit && !fault_wr) |=> !shut_flag); // R11

  AST_RESUME_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(force_safe) |-> $past(period_start)); // R12
endmodule

bind epwm_bridge epwm_bridge_chk #(.DUTY_W(DUTY_W)) u_chk (
  .clk, .rst_n, .lane_a, .lane_b, .fault_hit, .force_safe, .fault_wr,
  .auto_rs, .period_start, .duty_live, .shut_flag, .pwm_out, .pwm_oe,
  .safe_out, .safe_oe
);

// File: tb/test_epwm_bridge.sv
module test_epwm_bridge;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] fault_in = '0;
  logic [3:0] pwm_out, pwm_oe;
  logic       shut_flag;

  int    vectors = 0;
  int    errors = 0;
  bit    done = 0;
  string phase = "R1";

  epwm_bridge i_epwm_bridge (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .fault_in,
    .pwm_out, .pwm_oe, .shut_flag
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- behavioural reference model ----------------
  int m_per, m_dhi, m_pc, m_cnt, m_duty, m_ha, m_hb;
  bit [7:0] m_cfg, m_dreg;
  bit [6:0] m_freg;
  bit m_run, m_sd, m_held;
  bit [2:0] m_s1, m_s2;
  bit [3:0] m_out, m_oe;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_per = 255; m_dhi = 0; m_cfg = 0; m_dreg = 0; m_freg = 0; m_run = 0;
      m_pc = 0; m_cnt = 0; m_duty = 0; m_ha = 0; m_hb = 0;
      m_s1 = 0; m_s2 = 0; m_sd = 0; m_held = 0; m_out = 0; m_oe = 0;
    end else begin
      int lim, dead, mode;
      bit tick, endc, ps, raw, la, lb, hit, frc;
      bit [3:0] lvl, oe;
      lim  = (m_cfg[7:6] == 0) ? 0 : (m_cfg[7:6] == 1) ? 3 : 15;
      tick = m_run && (m_pc >= lim);
      endc = (m_cnt / 4 >= m_per) && (m_cnt % 4 == 3);
      ps   = tick && endc;
      raw  = m_cnt < m_duty;
      dead = int'(m_dreg[6:0]);
      la   = raw && (m_ha >= dead);
      lb   = !raw && (m_hb >= dead);
      hit  = (m_s2 & m_freg[2:0]) != 0;
      frc  = m_sd || hit || m_held;
      mode = int'(m_cfg[1:0]);
      lvl = 0; oe = 0;
      if (mode == 0) begin oe[0] = 1; lvl[0] = raw; end
      else if (mode == 1) begin oe[1:0] = 2'b11; lvl[0] = la; lvl[1] = lb; end
      else if (mode == 2) begin oe = 4'hF; lvl[0] = 1; lvl[3] = raw; end
      else begin oe = 4'hF; lvl[2] = 1; lvl[1] = raw; end
      for (int i = 0; i < 4; i++) begin
        bit inv;
        bit [1:0] code;
        inv  = (i % 2 == 0) ? m_cfg[2] : m_cfg[3];
        code = (i % 2 == 0) ? m_freg[4:3] : m_freg[6:5];
        if (frc) begin
          m_oe[i]  = !code[1];
          m_out[i] = !code[1] && code[0];
        end else begin
          m_oe[i]  = oe[i];
          m_out[i] = oe[i] && (lvl[i] ^ inv);
        end
      end
      // state updates
      if (m_run) m_pc = tick ? 0 : m_pc + 1;
      if (tick) m_cnt = endc ? 0 : m_cnt + 1;
      if (ps) m_duty = m_dhi * 4 + int'(m_cfg[5:4]);
      m_ha = !raw ? 0 : (m_ha < dead ? m_ha + 1 : m_ha);
      m_hb = raw ? 0 : (m_hb < dead ? m_hb + 1 : m_hb);
      if (m_sd || hit) m_held = 1; else if (ps) m_held = 0;
      if (hit) m_sd = 1;
      else if (wr_en && wr_addr == 4) m_sd = wr_data[7];
      else if (m_dreg[7] && m_sd) m_sd = 0;
      m_s2 = m_s1; m_s1 = fault_in;
      if (wr_en) begin
        case (wr_addr)
          0: m_per = int'(wr_data);
          1: m_dhi = int'(wr_data);
          2: m_cfg = wr_data;
          3: m_dreg = wr_data;
          4: m_freg = wr_data[6:0];
          5: m_run = wr_data[0];
          default: ;
        endcase
      end
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      vectors++;
      if (pwm_out !== m_out || pwm_oe !== m_oe || shut_flag !== m_sd) begin
        errors++;
        $display("FAIL %s: out=%b oe=%b flag=%b expected out=%b oe=%b flag=%b",
                 phase, pwm_out, pwm_oe, shut_flag, m_out, m_oe, m_sd);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1; wr_addr = 3'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1;
    // R1: reset state
    idle(2);
    chk("R1 oe", int'(pwm_oe), 1);
    chk("R1 out", int'(pwm_out), 0);
    chk("R1 flag", int'(shut_flag), 0);

    // R13 / R2: program period 4, duty 9, prescale 1, run
    phase = "R13";
    wr(0, 4); wr(1, 2); wr(2, 8'b00_01_00_00); wr(5, 1);
    phase = "R2 presc1"; idle(80);
    phase = "R2 presc4"; wr(2, 8'b01_01_00_00); idle(240);
    phase = "R2 presc16"; wr(2, 8'b10_10_00_00); idle(700);
    phase = "R2 stopped"; wr(5, 0); idle(40); wr(5, 1);
    // R3: duty changes mid-period
    phase = "R3"; wr(2, 8'b00_11_00_00); idle(7); wr(1, 1); idle(13); wr(1, 3); idle(60);
    // R4: duty above period
    phase = "R4"; wr(1, 8'hFF); idle(30);
    for (int i = 0; i < 24; i++) begin
      chk("R4 always high", int'(pwm_out[0]), 1);
      idle(1);
    end
    // R5: steering modes
    wr(1, 2);
    phase = "R5 fwd";  wr(2, 8'b00_01_00_10); idle(50);
    phase = "R5 rev";  wr(2, 8'b00_01_00_11); idle(50);
    phase = "R5 half"; wr(2, 8'b00_01_00_01); idle(50);
    // R6: polarity
    phase = "R6 ac";   wr(2, 8'b00_01_01_10); idle(50);
    phase = "R6 bd";   wr(2, 8'b00_01_10_11); idle(50);
    // R7: dead band in half-bridge
    phase = "R7"; wr(3, 3); wr(2, 8'b00_10_00_01); idle(30);
    for (int i = 0; i < 40; i++) begin
      chk("R7 no overlap", int'(pwm_out[0] && pwm_out[1]), 0);
      idle(1);
    end
    wr(3, 6); idle(60);
    // R8: unselected source has no effect
    phase = "R8 masked"; wr(2, 8'b00_10_00_10); wr(3, 0);
    wr(4, 8'b0_10_01_001); fault_in = 3'b010; idle(10);
    chk("R8 masked flag", int'(shut_flag), 0);
    fault_in = 0; idle(10);
    // R8/R9: selected fault forces safe levels
    phase = "R8 forced"; fault_in = 3'b001; idle(1);
    chk("R9 flag not yet", int'(shut_flag), 0);
    idle(2);
    chk("R9 flag set", int'(shut_flag), 1);
    chk("R8 safe oe", int'(pwm_oe), 4'b0101);
    chk("R8 safe out", int'(pwm_out), 4'b0101);
    // R9: fault dominates a clearing write
    phase = "R9"; wr(4, 8'b0_10_01_001); idle(5);
    chk("R9 fault wins", int'(shut_flag), 1);
    // R10: manual recovery
    phase = "R10"; fault_in = 0; idle(30);
    chk("R10 sticky", int'(shut_flag), 1);
    wr(4, 8'b0_00_10_001); idle(1);
    // R12: pins held until boundary
    phase = "R12"; idle(2);
    chk("R12 still safe", int'(pwm_oe), 4'b1010);
    idle(60);
    // R11: automatic restart
    phase = "R11"; wr(3, 8'h80); wr(4, 8'b0_01_00_110);
    fault_in = 3'b100; idle(6); fault_in = 0; idle(3);
    chk("R11 auto clear", int'(shut_flag), 0);
    idle(60);
    fault_in = 3'b010; idle(4); fault_in = 0; idle(80);
    // R10: write bit 7 sets the flag in manual mode
    phase = "R10 set"; wr(3, 0); wr(4, 8'b1_00_00_000); idle(3);
    chk("R10 set by write", int'(shut_flag), 1);
    wr(4, 0); idle(60);
    finish_run();
  end
endmodule